// File: doc/BRIEF.md
# Two-Rank Input Register for a 16-bit DAC

This block is the digital front end of a 16-bit digital-to-analog converter. A host loads a code word into a first-rank holding register, either one bit at a time on a strobe pin or as two 8-bit halves on a small parallel bus. A mode pin chooses between the two methods. A separate load pin then copies the holding register into a second-rank code register, which drives the converter. Because the two ranks are separate, several converters can be preloaded and then updated together.

In serial mode the holding register works as a shift register. The bit that will be pushed out next appears on a serial output pin, so converters can be chained and fed from one data line. A clear pin forces the code register to one of two zero codes: the unipolar zero or the mid-scale (bipolar) zero. The lower-half write pin picks which one. Clear leaves the holding register untouched, so a later load restores the earlier word.

All control pins are sampled by one system clock through two-stage synchronisers. Strobe edges are detected after synchronisation. Only the forcing of the output during clear takes effect without the clock.

Top module: `dacif_top`

## Requirements
- R1: With `byte_sel` low (serial mode) and `data_in[1]` low, each rising edge of `cs_strobe` shifts the holding register toward its most significant bit and takes `data_in[0]` into bit 0. After 16 edges the first bit sent is the most significant bit.
- R2: With `byte_sel` low and `data_in[1]` high, each rising edge of `cs_strobe` shifts toward bit 0 and takes `data_in[0]` into bit 15. After 16 edges the first bit sent is the least significant bit.
- R3: `ser_out` always shows the bit that the next strobe edge pushes out. That is bit 15 in most-significant-first order and bit 0 in least-significant-first order. A loaded word therefore leaves in its sending order over the next 16 edges.
- R4: While `load_dac` is high and `clear` is low, `dac_code` follows the holding register, including writes made during the high level. While `load_dac` is low, `dac_code` keeps its value.
- R5: `clear` forces `dac_code` at once, without waiting for a clock edge. It does not change the holding register, so a load after clear is released brings back the word held before.
- R6: During clear, `lo_wr` low selects code 0x0000 and `lo_wr` high selects code 0x8000.
- R7: With `byte_sel` high, a high level on `hi_wr` writes `data_in` into bits 15:8 and a high level on `lo_wr` writes it into bits 7:0. The two halves may be written in either order.
- R8: In serial mode `hi_wr` and `lo_wr` do not change the holding register.
- R9: After reset both registers hold 0x0000 and `ser_out` is 0.
- R10: When `clear` and `load_dac` are both high, `dac_code` stays at the zero code. It also stays there after clear is released, until a load occurs with clear low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_sel | input | 1 | 1 = byte mode, 0 = serial mode |
| data_in | input | 8 | Byte bus. In serial mode bit 0 is the serial data and bit 1 is the order select |
| cs_strobe | input | 1 | Strobe; a rising edge captures one serial bit |
| load_dac | input | 1 | Level-sensitive transfer from the holding register to the code register |
| hi_wr | input | 1 | Level-sensitive upper-half write enable (byte mode) |
| lo_wr | input | 1 | Level-sensitive lower-half write enable (byte mode); clear target select |
| clear | input | 1 | Forces the code register to a zero code |
| dac_code | output | 16 | Code to the converter |
| ser_out | output | 1 | Serial output for chaining |

## Verification
On every cycle, the assertions check the following:
- The holding register stays still when no strobe edge arrives in serial mode, or when no enable is high in byte mode.
- A most-significant-first shift takes in the data bit.
- The code register only ever holds a zero code during clear.
- The code register holds when neither load nor clear is active.

Only the bench scenarios can show the whole-word results. These are: the correct word after 16 edges in each order, the daisy-chain output sequence, both byte orders, the change of `dac_code` without a clock during clear, and the return of the old word after clear.

The data bus has no valid/ready handshake and applies no back-pressure. The host must hold `data_in` and the mode pins steady for at least three clock cycles around each strobe or enable.

// File: rtl/dacif_pkg.sv
`timescale 1ns/1ps
package dacif_pkg;
  localparam int CODE_W = 16;
  localparam int BYTE_W = 8;
  localparam int LANES  = CODE_W / BYTE_W;

  typedef enum logic {
    SHIFT_MSB_FIRST = 1'b0,
    SHIFT_LSB_FIRST = 1'b1
  } shift_order_e;

  function automatic logic [CODE_W-1:0] zero_code(input logic bipolar);
    logic [CODE_W-1:0] z;
    z = '0;
    z[CODE_W-1] = bipolar;
    return z;
  endfunction
endpackage

// File: rtl/dacif_sync.sv
`timescale 1ns/1ps
module dacif_sync #(
  parameter int N      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] sync_out
);
  logic [N-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[s] <= '0;
        else        pipe[s] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[s] <= '0;
        else        pipe[s] <= pipe[s-1];
      end
    end
  end

  assign sync_out = pipe[STAGES-1];
endmodule

// File: rtl/dacif_input_rank.sv
`timescale 1ns/1ps
module dacif_input_rank
  import dacif_pkg::*;
#(
  parameter int W  = CODE_W,
  parameter int BW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          serial_mode,
  input  shift_order_e  order,
  input  logic          sin,
  input  logic          cs_rise,
  input  logic [BW-1:0] byte_bus,
  input  logic          hi_wr,
  input  logic          lo_wr,
  output logic [W-1:0]  word,
  output logic          sout
);
  localparam int NLANE = W / BW;
  localparam int HI_FROM = NLANE / 2;

  logic [W-1:0] word_nxt;

  always_comb begin
    word_nxt = word;
    if (serial_mode) begin
      if (cs_rise) begin
        if (order == SHIFT_LSB_FIRST) word_nxt = {sin, word[W-1:1]};
        else                          word_nxt = {word[W-2:0], sin};
      end
    end else begin
      for (int l = 0; l < NLANE; l++) begin
        if ((l >= HI_FROM) ? hi_wr : lo_wr)
          word_nxt[l*BW +: BW] = byte_bus;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word <= '0;
    else        word <= word_nxt;
  end

  assign sout = (order == SHIFT_LSB_FIRST) ? word[0] : word[W-1];

  // R1
  shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (serial_mode && !cs_rise) |=> $stable(word));

  // R1
  msb_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (serial_mode && cs_rise && order == SHIFT_MSB_FIRST) |=> (word[0] == $past(sin)));

  // R7
  byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!serial_mode && !hi_wr && !lo_wr) |=> $stable(word));
endmodule

// File: rtl/dacif_dac_rank.sv
`timescale 1ns/1ps
module dacif_dac_rank
  import dacif_pkg::*;
#(
  parameter int W = CODE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_hold,
  input  logic         bipolar,
  input  logic         load,
  input  logic [W-1:0] in_word,
  output logic [W-1:0] code_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        code_q <= '0;
    else if (clr_hold) code_q <= zero_code(bipolar);
    else if (load)     code_q <= in_word;
  end

  // R10
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hold |=> (code_q == '0 || code_q == {1'b1, {(W-1){1'b0}}}));

  // R4
  load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_hold && !load) |=> $stable(code_q));
endmodule

// File: rtl/dacif_top.sv
`timescale 1ns/1ps
module dacif_top
  import dacif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_sel,
  input  logic [BYTE_W-1:0] data_in,
  input  logic              cs_strobe,
  input  logic              load_dac,
  input  logic              hi_wr,
  input  logic              lo_wr,
  input  logic              clear,
  output logic [CODE_W-1:0] dac_code,
  output logic              ser_out
);
  localparam int NSYNC = 5;

  logic [NSYNC-1:0] raw_ctl, syn_ctl;
  logic cs_s, ld_s, hi_s, lo_s, clr_s, cs_d, cs_rise;
  logic [CODE_W-1:0] hold_word, code_q;
  shift_order_e order;

  assign raw_ctl = {clear, lo_wr, hi_wr, load_dac, cs_strobe};
  assign {clr_s, lo_s, hi_s, ld_s, cs_s} = syn_ctl;

  dacif_sync #(.N(NSYNC), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(raw_ctl), .sync_out(syn_ctl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_d <= 1'b0;
    else        cs_d <= cs_s;
  end
  assign cs_rise = cs_s & ~cs_d;

  assign order = data_in[1] ? SHIFT_LSB_FIRST : SHIFT_MSB_FIRST;

  dacif_input_rank #(.W(CODE_W), .BW(BYTE_W)) u_in (
    .clk(clk), .rst_n(rst_n), .serial_mode(~byte_sel), .order(order),
    .sin(data_in[0]), .cs_rise(cs_rise), .byte_bus(data_in),
    .hi_wr(hi_s), .lo_wr(lo_s), .word(hold_word), .sout(ser_out)
  );

  dacif_dac_rank #(.W(CODE_W)) u_dac (
    .clk(clk), .rst_n(rst_n), .clr_hold(clr_s), .bipolar(lo_s),
    .load(ld_s), .in_word(hold_word), .code_q(code_q)
  );

  assign dac_code = clear ? zero_code(lo_wr) : code_q;
endmodule

// File: tb/dacif_top_bench.sv
`timescale 1ns/1ps
module dacif_top_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic byte_sel = 1'b0;
  logic [7:0] data_in = '0;
  logic cs_strobe = 1'b0, load_dac = 1'b0, hi_wr = 1'b0, lo_wr = 1'b0, clear = 1'b0;
  logic [15:0] dac_code;
  logic ser_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dacif_top u_dacif_top (
    .clk(clk), .rst_n(rst_n), .byte_sel(byte_sel), .data_in(data_in),
    .cs_strobe(cs_strobe), .load_dac(load_dac), .hi_wr(hi_wr), .lo_wr(lo_wr),
    .clear(clear), .dac_code(dac_code), .ser_out(ser_out)
  );

  // [19]=byte mode, [18]=lsb first, [17]=high byte first, [15:0]=word
  localparam logic [19:0] VEC [8] = '{
    {4'b0000, 16'hA5C3}, {4'b0100, 16'h1234}, {4'b1000, 16'hBEEF}, {4'b1010, 16'h0F0F},
    {4'b0000, 16'hFFFF}, {4'b0100, 16'h8001}, {4'b1010, 16'h0000}, {4'b1000, 16'h7FFE}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cs_edge(input logic b);
    data_in[0] = b;
    tick(2); cs_strobe = 1'b1; tick(4); cs_strobe = 1'b0; tick(4);
  endtask

  task automatic send_serial(input logic [15:0] w, input logic lsb);
    byte_sel = 1'b0; data_in[1] = lsb;
    for (int i = 0; i < 16; i++) cs_edge(lsb ? w[i] : w[15-i]);
  endtask

  task automatic write_byte(input logic hi, input logic [7:0] v);
    byte_sel = 1'b1; data_in = v; tick(2);
    if (hi) hi_wr = 1'b1; else lo_wr = 1'b1;
    tick(4); hi_wr = 1'b0; lo_wr = 1'b0; tick(4);
  endtask

  task automatic pulse_ld;
    load_dac = 1'b1; tick(6); load_dac = 1'b0; tick(4);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] got;
    tick(3);
    // R9 reset state
    chk("R9 dac_code after reset", dac_code, 16'h0000);
    chk("R9 ser_out after reset", {15'b0, ser_out}, 16'h0000);
    rst_n = 1'b1; tick(3);

    // R1 R2 R7 R4 table walk
    for (int v = 0; v < 8; v++) begin
      if (VEC[v][19]) begin
        if (VEC[v][17]) begin write_byte(1, VEC[v][15:8]); write_byte(0, VEC[v][7:0]); end
        else            begin write_byte(0, VEC[v][7:0]); write_byte(1, VEC[v][15:8]); end
      end else send_serial(VEC[v][15:0], VEC[v][18]);
      pulse_ld;
      chk(VEC[v][19] ? "R7 byte load" : (VEC[v][18] ? "R2 lsb serial" : "R1 msb serial"),
          dac_code, VEC[v][15:0]);
    end

    // R4 hold while load low
    send_serial(16'h3C3C, 1'b0);
    chk("R4 hold with load low", dac_code, 16'h7FFE);
    pulse_ld;
    chk("R4 load after hold", dac_code, 16'h3C3C);

    // R8 enables ignored in serial mode
    byte_sel = 1'b0; data_in = 8'h55;
    hi_wr = 1'b1; lo_wr = 1'b1; tick(6); hi_wr = 1'b0; lo_wr = 1'b0; tick(4);
    data_in = 8'h00; pulse_ld;
    chk("R8 enables ignored in serial", dac_code, 16'h3C3C);

    // R3 daisy chain, msb first
    send_serial(16'hC6A1, 1'b0);
    chk("R3 ser_out msb first before shift", {15'b0, ser_out}, 16'h0001);
    got = '0;
    for (int i = 0; i < 16; i++) begin got = {got[14:0], ser_out}; cs_edge(1'b0); end
    chk("R3 chained word msb first", got, 16'hC6A1);
    // R3 lsb first
    send_serial(16'h5B3E, 1'b1);
    got = '0;
    for (int i = 0; i < 16; i++) begin got = {ser_out, got[15:1]}; cs_edge(1'b0); end
    chk("R3 chained word lsb first", got, 16'h5B3E);

    // R5 R6 R10 unipolar clear
    send_serial(16'h9ABC, 1'b0); pulse_ld;
    lo_wr = 1'b0; clear = 1'b1; #1;
    chk("R5 clear acts without clock", dac_code, 16'h0000);
    tick(4); load_dac = 1'b1; tick(6);
    chk("R10 clear over load", dac_code, 16'h0000);
    load_dac = 1'b0; tick(2); clear = 1'b0; tick(6);
    chk("R10 zero held after release", dac_code, 16'h0000);
    pulse_ld;
    chk("R5 restore after unipolar clear", dac_code, 16'h9ABC);

    // R6 bipolar clear in serial mode
    lo_wr = 1'b1; tick(4); clear = 1'b1; #1;
    chk("R6 bipolar zero", dac_code, 16'h8000);
    tick(6);
    chk("R6 bipolar zero held", dac_code, 16'h8000);
    clear = 1'b0; tick(2); lo_wr = 1'b0; tick(6);
    chk("R6 code register bipolar", dac_code, 16'h8000);
    pulse_ld;
    chk("R5 restore after bipolar clear", dac_code, 16'h9ABC);

    // R4 level load is transparent
    load_dac = 1'b1; tick(6);
    write_byte(1, 8'h4D); write_byte(0, 8'hE2); tick(2);
    chk("R4 follows while load high", dac_code, 16'h4DE2);
    load_dac = 1'b0; tick(4);
    write_byte(0, 8'h11); tick(2);
    chk("R4 holds after load low", dac_code, 16'h4DE2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule